// File: doc/BRIEF.md
# Indexed Configuration RAM Port

This block holds a small configuration memory that a host reaches through two byte-wide I/O ports. A write to the index port selects a byte location. A later write to the data port stores into that location, and the data-port read value always shows the selected byte. The index write also carries a mask bit for the non-maskable interrupt. That bit is held in a register and driven out on its own pin, so one write both selects a location and sets the interrupt mask.

The logical address space is 128 bytes. A build parameter can shrink the physical array to 64 bytes. The upper half of the address space then lands on the lower half.

One location is a read-only status byte that reports whether the backing supply is good. A checker adds up a fixed range of configuration bytes as a 16-bit sum and compares the result with a 16-bit word stored just above that range. Any write into the covered range starts the sum again, and a pin reports whether the sum matches.

A synchronous reset clears only the index and the interrupt mask. The memory keeps its contents.

Top module: `cfgport`

## Requirements
- R1: An index write (ioWrite=1, ioSel=0) takes bits 6..0 of ioWData as the byte address. Bit 7 never takes part in addressing, and the locations 00h..7Fh are all distinct when PHYS_BYTES=128.
- R2: Bit 7 of each index write is registered onto nmiDisable: 1 masks the interrupt and 0 unmasks it. The new value appears from the cycle after the write.
- R3: A data write (ioWrite=1, ioSel=1) stores ioWData at the selected address. rdData shows the selected byte combinationally, so a new index or new data is visible in the cycle after the write.
- R4: With PHYS_BYTES=64, address bit 6 is ignored, so addresses 40h..7Fh reach the same bytes as 00h..3Fh. This includes the status byte at 4Dh.
- R5: checksumOk is 1 when the 16-bit sum of bytes 10h..2Dh equals {byte 2Eh, byte 2Fh}, with the high byte at 2Eh. Any data write into 10h..2Fh restarts the sum, and checksumOk takes the new result within 32 cycles of that write. checksumOk holds its previous value while the sum is being recomputed.
- R6: Address 0Dh reads as {battGood, 7'b0000000}, and data writes to it have no effect.
- R7: The index and nmiDisable keep their values across data-port accesses, so repeated reads return the same location.
- R8: A synchronous reset (rst=1) clears the index to 00h, nmiDisable to 0 and checksumOk to 0, leaves the memory contents intact, and starts a fresh sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioWrite | input | 1 | Write strobe for the selected port |
| ioSel | input | 1 | Port select: 0 = index port, 1 = data port |
| ioWData | input | 8 | Write data |
| battGood | input | 1 | Backing supply good |
| rdData | output | 8 | Data-port read value (selected byte) |
| nmiDisable | output | 1 | Registered interrupt mask from index bit 7 |
| checksumOk | output | 1 | Stored checksum word matches the recomputed sum |

## Verification
The assertions check the following on every cycle:
- the interrupt-mask latch follows each index write and stays put across data-port accesses;
- an index write of 0Dh makes the next read return the supply status;
- checksumOk does not move while a sum is running;
- the internal sum strobes never overlap;
- reset clears the mask.

Some behaviours only the bench scenarios can show:
- that bit 7 of the index is excluded from the address;
- that the 64-byte build aliases;
- that the high byte of the checksum word belongs at 2Eh, not 2Fh;
- that the memory survives a reset.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int LOG_AW = 7;
  localparam logic [LOG_AW-1:0] STATUS_ADDR = 7'h0D;
  localparam logic [LOG_AW-1:0] SUM_FIRST   = 7'h10;
  localparam logic [LOG_AW-1:0] SUM_LAST    = 7'h2D;
  localparam logic [LOG_AW-1:0] CK_HI       = 7'h2E;
  localparam logic [LOG_AW-1:0] CK_LO       = 7'h2F;
  localparam int SCAN_LEN = int'(SUM_LAST) - int'(SUM_FIRST) + 1;
  localparam int CW = $clog2(SCAN_LEN);
  localparam int SUM_W = 16;

  typedef struct packed {
    logic              memWr;
    logic [LOG_AW-1:0] memAddr;
    logic [LOG_AW-1:0] scanAddr;
    logic              sumClr;
    logic              sumAdd;
    logic              cmpLoad;
  } strobe_t;
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgp_pkg::*;
#(
  parameter int PHYS_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ioWrite,
  input  logic       ioSel,
  input  logic [7:0] ioWData,
  output logic       nmiDisable,
  output logic       scanBusy,
  output strobe_t    strb
);
  localparam logic [LOG_AW-1:0] ADDR_MASK = LOG_AW'(PHYS_BYTES - 1);
  localparam logic [CW-1:0] LAST_OFF = CW'(SCAN_LEN - 1);

  logic [LOG_AW-1:0] idxReg;
  logic              nmiReg;
  logic [CW-1:0]     cnt;
  logic              doneQ;
  logic [LOG_AW-1:0] physIdx;
  logic              dataWr;
  logic              inRange;
  logic              start;

  assign physIdx = idxReg & ADDR_MASK;
  assign dataWr  = ioWrite & ioSel;
  assign inRange = (physIdx >= SUM_FIRST) && (physIdx <= CK_LO);
  assign start   = dataWr & inRange;

  always_comb begin
    strb.memWr    = dataWr;
    strb.memAddr  = physIdx;
    strb.scanAddr = SUM_FIRST + LOG_AW'(cnt);
    strb.sumClr   = start;
    strb.sumAdd   = scanBusy & ~start;
    strb.cmpLoad  = doneQ & ~start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idxReg   <= '0;
      nmiReg   <= 1'b0;
      scanBusy <= 1'b1;
      cnt      <= '0;
      doneQ    <= 1'b0;
    end else begin
      if (ioWrite && !ioSel) begin
        idxReg <= ioWData[6:0];
        nmiReg <= ioWData[7];
      end
      if (start) begin
        scanBusy <= 1'b1;
        cnt      <= '0;
        doneQ    <= 1'b0;
      end else if (scanBusy) begin
        if (cnt == LAST_OFF) begin
          scanBusy <= 1'b0;
          doneQ    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        doneQ <= 1'b0;
      end
    end
  end

  assign nmiDisable = nmiReg;
endmodule

// File: rtl/cfgport_dp.sv
module cfgport_dp
  import cfgp_pkg::*;
#(
  parameter int PHYS_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strb,
  input  logic [7:0] ioWData,
  input  logic       battGood,
  output logic [7:0] rdData,
  output logic       checksumOk
);
  localparam int PAW  = $clog2(PHYS_BYTES);
  localparam int HI_I = int'(CK_HI);
  localparam int LO_I = int'(CK_LO);

  logic [7:0]       mem [PHYS_BYTES];
  logic [SUM_W-1:0] acc;
  logic             okReg;
  logic [PAW-1:0]   wa;
  logic [PAW-1:0]   sa;

  assign wa = strb.memAddr[PAW-1:0];
  assign sa = strb.scanAddr[PAW-1:0];

  always_ff @(posedge clk) begin
    if (strb.memWr && strb.memAddr != STATUS_ADDR) mem[wa] <= ioWData;
  end

  always_comb begin
    if (strb.memAddr == STATUS_ADDR) rdData = {battGood, 7'b0};
    else                             rdData = mem[wa];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      okReg <= 1'b0;
    end else begin
      if (strb.sumClr)      acc <= '0;
      else if (strb.sumAdd) acc <= acc + {{(SUM_W-8){1'b0}}, mem[sa]};
      if (strb.cmpLoad) okReg <= (acc == {mem[HI_I], mem[LO_I]});
    end
  end

  assign checksumOk = okReg;
endmodule

// File: rtl/cfgport.sv
module cfgport
  import cfgp_pkg::*;
#(
  parameter int PHYS_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ioWrite,
  input  logic       ioSel,
  input  logic [7:0] ioWData,
  input  logic       battGood,
  output logic [7:0] rdData,
  output logic       nmiDisable,
  output logic       checksumOk
);
  strobe_t strb;
  logic    scanBusy;

  cfgport_ctrl #(.PHYS_BYTES(PHYS_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .ioWrite(ioWrite), .ioSel(ioSel),
    .ioWData(ioWData), .nmiDisable(nmiDisable), .scanBusy(scanBusy),
    .strb(strb)
  );

  cfgport_dp #(.PHYS_BYTES(PHYS_BYTES)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .ioWData(ioWData),
    .battGood(battGood), .rdData(rdData), .checksumOk(checksumOk)
  );
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ioWrite,
  input logic       ioSel,
  input logic [7:0] ioWData,
  input logic       battGood,
  input logic [7:0] rdData,
  input logic       nmiDisable,
  input logic       checksumOk,
  input logic       scanBusy,
  input strobe_t    strb
);
  p_nmi_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (ioWrite && !ioSel) |=> (nmiDisable == $past(ioWData[7])));

  p_idx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ioWrite && ioSel) |=> $stable(nmiDisable));

  p_status_read_r6: assert property (@(posedge clk) disable iff (rst)
    (ioWrite && !ioSel && ioWData[6:0] == 7'h0D) |=> (rdData == {battGood, 7'b0}));

  p_ok_hold_r5: assert property (@(posedge clk) disable iff (rst)
    scanBusy |=> $stable(checksumOk));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.sumClr, strb.sumAdd, strb.cmpLoad}));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!nmiDisable && !checksumOk));
endmodule

bind cfgport cfgport_chk u_chk (.*);

// File: tb/cfgport_test.sv
module cfgport_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ioWrite = 1'b0;
  logic ioSel = 1'b0;
  logic [7:0] ioWData = '0;
  logic battGood = 1'b1;
  logic [7:0] rdData, rd64;
  logic nmiDisable, nmi64, checksumOk, ok64;
  int nChecks = 0;
  int nFails = 0;
  logic [15:0] goodSum;

  always #2 clk = ~clk;

  cfgport #(.PHYS_BYTES(128)) uut (
    .clk(clk), .rst(rst), .ioWrite(ioWrite), .ioSel(ioSel), .ioWData(ioWData),
    .battGood(battGood), .rdData(rdData), .nmiDisable(nmiDisable), .checksumOk(checksumOk));

  cfgport #(.PHYS_BYTES(64)) uut64 (
    .clk(clk), .rst(rst), .ioWrite(ioWrite), .ioSel(ioSel), .ioWData(ioWData),
    .battGood(battGood), .rdData(rd64), .nmiDisable(nmi64), .checksumOk(ok64));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    ioWrite = 1'b1; ioSel = sel; ioWData = v;
    @(negedge clk);
    ioWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] val(input int i);
    return 8'(8'hC3 + i * 13);
  endfunction

  task automatic t_reset_state;
    chk("R8 nmi in reset", {15'b0, nmiDisable}, 16'h0);
    chk("R8 ok in reset", {15'b0, checksumOk}, 16'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_basic;
    wr(0, 8'h00); wr(1, 8'h5A);
    wr(0, 8'h7F); wr(1, 8'h3C);
    wr(0, 8'hE0); wr(1, 8'h77);
    chk("R3 read after data write", {8'h0, rdData}, 16'h0077);
    wr(0, 8'h60); chk("R1 bit7 not address", {8'h0, rdData}, 16'h0077);
    wr(0, 8'h7F); chk("R1 top address", {8'h0, rdData}, 16'h003C);
    wr(0, 8'h00); chk("R3 address 00", {8'h0, rdData}, 16'h005A);
  endtask

  task automatic t_nmi;
    wr(0, 8'h85); chk("R2 mask set", {15'b0, nmiDisable}, 16'h1);
    wr(0, 8'h05); chk("R2 mask clear", {15'b0, nmiDisable}, 16'h0);
  endtask

  task automatic t_hold;
    wr(0, 8'hFF); wr(1, 8'h9E);
    chk("R7 mask kept over data write", {15'b0, nmiDisable}, 16'h1);
    idle(1); chk("R7 first read", {8'h0, rdData}, 16'h009E);
    idle(3); chk("R7 repeat read", {8'h0, rdData}, 16'h009E);
  endtask

  task automatic t_status;
    wr(0, 8'h0D);
    battGood = 1'b1; idle(1); chk("R6 supply good", {8'h0, rdData}, 16'h0080);
    battGood = 1'b0; idle(1); chk("R6 supply lost", {8'h0, rdData}, 16'h0000);
    wr(1, 8'hFF); chk("R6 write ignored", {8'h0, rdData}, 16'h0000);
    battGood = 1'b1; idle(1); chk("R6 after write", {8'h0, rdData}, 16'h0080);
  endtask

  task automatic t_alias;
    wr(0, 8'h05); wr(1, 8'h11);
    wr(0, 8'h45); wr(1, 8'hAA);
    wr(0, 8'h05);
    chk("R4 64-byte alias", {8'h0, rd64}, 16'h00AA);
    chk("R1 128-byte distinct", {8'h0, rdData}, 16'h0011);
    wr(0, 8'h4D);
    chk("R4 status alias", {8'h0, rd64}, 16'h0080);
  endtask

  task automatic t_checksum;
    goodSum = '0;
    for (int i = 0; i < 30; i++) begin
      wr(0, 8'(8'h10 + i)); wr(1, val(i));
      goodSum = goodSum + 16'(val(i));
    end
    wr(0, 8'h2E); wr(1, goodSum[15:8]);
    wr(0, 8'h2F); wr(1, goodSum[7:0]);
    idle(40);
    chk("R5 match", {15'b0, checksumOk}, 16'h1);
    chk("R5 match 64", {15'b0, ok64}, 16'h1);
    wr(0, 8'h20); wr(1, val(16) ^ 8'h01);
    idle(5); chk("R5 held during sum", {15'b0, checksumOk}, 16'h1);
    idle(35); chk("R5 mismatch", {15'b0, checksumOk}, 16'h0);
    wr(1, val(16));
    wr(0, 8'h2E); wr(1, goodSum[7:0]);
    wr(0, 8'h2F); wr(1, goodSum[15:8]);
    idle(40); chk("R5 byte order", {15'b0, checksumOk}, 16'h0);
    wr(1, goodSum[7:0]);
    wr(0, 8'h2E); wr(1, goodSum[15:8]);
    idle(40); chk("R5 restored", {15'b0, checksumOk}, 16'h1);
  endtask

  task automatic t_reset_keep;
    wr(0, 8'hA7);
    chk("R2 mask before reset", {15'b0, nmiDisable}, 16'h1);
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0;
    chk("R8 mask cleared", {15'b0, nmiDisable}, 16'h0);
    chk("R8 index 00 and RAM kept", {8'h0, rdData}, 16'h005A);
    idle(40); chk("R8 sum after reset", {15'b0, checksumOk}, 16'h1);
  endtask

  initial begin
    idle(3);
    t_reset_state();
    t_basic();
    t_nmi();
    t_hold();
    t_status();
    t_alias();
    t_checksum();
    t_reset_keep();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule